// File: doc/BRIEF.md
# Block-Transfer Address Sequencer

This block turns one multi-register memory transfer command into a run of single-word accesses. A command carries a base address, a 16-bit register mask, a direction flag (load or store), one of four stepping modes and a base-update flag. Once started, the block issues one word access per set mask bit. Accesses always go in rising register order at rising word addresses. The mode only decides where the run begins and what the updated base becomes. Each access is held on a request/acknowledge pair until memory accepts it.

A command runs to the end once it is started. A new start pulse is ignored until the block is idle again. After the last access the block spends one finishing cycle. In that cycle it pulses completion and, if the command asked for it, offers the updated base value to the register file.

The controller has four states. `ST_IDLE` waits for a start pulse and captures the command (transition IDLE→SETUP). `ST_SETUP` computes the first address and the final base. It goes to XFER when the mask is non-empty and to FINISH when the mask is empty. `ST_XFER` holds a request until it is acknowledged. It stays in XFER while mask bits remain and moves to FINISH after the acknowledge of the last bit. `ST_FINISH` pulses completion and returns to IDLE.

Top module: `lsm_addr_seq`

## Requirements
- R1: While reset is asserted and after its release, `busy_o`, `req_o`, `done_o` and `wb_valid_o` are 0 until a start is accepted.
- R2: A command with N set mask bits produces exactly N accepted accesses (`req_o` and `ack_i` both high at a clock edge). `req_reg_o` strictly rises from one access to the next, and each address is the previous address plus 4.
- R3: Mode code 2'b00 (increment, after) starts at base and gives an updated base of base+4N.
- R4: Mode code 2'b01 (increment, before) starts at base+4 and gives an updated base of base+4N.
- R5: Mode code 2'b10 (decrement, after) starts at base−4N+4 and gives an updated base of base−4N.
- R6: Mode code 2'b11 (decrement, before) starts at base−4N and gives an updated base of base−4N. All address arithmetic wraps modulo 2^32.
- R7: While `req_o` is high and `ack_i` is low, the address, register index and direction (`req_load_o`, 1 = load) stay unchanged. The direction equals the value captured at start.
- R8: An all-zero mask produces no access. `done_o` then rises two cycles after the start cycle, and the updated base equals the base.
- R9: `wb_valid_o` is high only together with `done_o`, and only when the base-update flag was 1 at start. `wb_value_o` then carries the updated base.
- R10: A start pulse seen while `busy_o` is high has no effect. The running command keeps its own addresses and count, and no second command follows it.
- R11: `done_o` is high for one cycle, exactly 2 + N·t cycles after the cycle in which the start was sampled. Here t is the number of cycles each access's request is held, up to and including its acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled in idle only |
| base_i | input | 32 | Base address |
| reg_mask_i | input | 16 | Register mask, bit r selects register r |
| load_i | input | 1 | 1 = load, 0 = store |
| mode_i | input | 2 | Stepping mode: bit 1 = decrement, bit 0 = before |
| wb_en_i | input | 1 | Request base update at the end |
| busy_o | output | 1 | Command in progress |
| req_o | output | 1 | Word access request |
| req_addr_o | output | 32 | Word address of the access |
| req_reg_o | output | 4 | Register index of the access |
| req_load_o | output | 1 | Direction of the access |
| ack_i | input | 1 | Memory accepts the current access |
| done_o | output | 1 | One-cycle completion pulse |
| wb_valid_o | output | 1 | Updated base is valid this cycle |
| wb_value_o | output | 32 | Updated base value |

## Verification
Commands are run in all four modes with masks of different shape: sparse, dense, all sixteen bits, a single high nibble and empty. Together these separate the start offset of each mode, the total step of the updated base and the rising register order. Bases close to zero and to the top of the address space show that subtraction and addition wrap. Acknowledge delays of one, two and three cycles separate a correct hold-and-latency behaviour from one that advances early or miscounts. A start injected in mid-run and runs with the base-update flag cleared show the commands that must be ignored or must offer no update.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
    typedef enum logic [1:0] {
        AM_INC_AFTER  = 2'b00,
        AM_INC_BEFORE = 2'b01,
        AM_DEC_AFTER  = 2'b10,
        AM_DEC_BEFORE = 2'b11
    } addr_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_XFER,
        ST_FINISH
    } seq_state_e;
endpackage

// File: rtl/lsm_span_calc.sv
module lsm_span_calc #(
    parameter int ADDR_W     = 32,
    parameter int NREG       = 16,
    parameter int WORD_BYTES = 4,
    localparam int CNT_W     = $clog2(NREG + 1)
) (
    input  logic [ADDR_W-1:0]  base,
    input  logic [NREG-1:0]    mask,
    input  lsm_pkg::addr_mode_e mode,
    output logic [ADDR_W-1:0]  first_addr,
    output logic [ADDR_W-1:0]  final_base,
    output logic [CNT_W-1:0]   count
);
    logic [ADDR_W-1:0] span;
    logic              going_down;
    logic              step_first;

    always_comb begin
        count = '0;
        for (int i = 0; i < NREG; i++) begin
            count = count + CNT_W'(mask[i]);
        end
    end

    assign span       = ADDR_W'(count) * ADDR_W'(WORD_BYTES);
    assign going_down = mode[1];
    assign step_first = mode[0];

    always_comb begin
        if (!going_down) begin
            final_base = base + span;
            first_addr = step_first ? base + ADDR_W'(WORD_BYTES) : base;
        end else begin
            final_base = base - span;
            first_addr = step_first ? base - span
                                    : base - span + ADDR_W'(WORD_BYTES);
        end
    end
endmodule

// File: rtl/lsm_low_pick.sv
module lsm_low_pick #(
    parameter int NREG   = 16,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic [NREG-1:0]  mask,
    output logic [IDX_W-1:0] idx,
    output logic             hit,
    output logic             more
);
    logic [NREG-1:0] sel;

    always_comb begin
        idx = '0;
        hit = 1'b0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (mask[i]) begin
                idx = IDX_W'(i);
                hit = 1'b1;
            end
        end
    end

    assign sel  = NREG'(1) << idx;
    assign more = |(mask & ~sel);
endmodule

// File: rtl/lsm_addr_seq.sv
module lsm_addr_seq #(
    parameter int ADDR_W     = 32,
    parameter int NREG       = 16,
    parameter int WORD_BYTES = 4,
    localparam int IDX_W     = $clog2(NREG),
    localparam int CNT_W     = $clog2(NREG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [NREG-1:0]   reg_mask_i,
    input  logic              load_i,
    input  logic [1:0]        mode_i,
    input  logic              wb_en_i,
    output logic              busy_o,
    output logic              req_o,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [IDX_W-1:0]  req_reg_o,
    output logic              req_load_o,
    input  logic              ack_i,
    output logic              done_o,
    output logic              wb_valid_o,
    output logic [ADDR_W-1:0] wb_value_o
);
    import lsm_pkg::*;

    seq_state_e state_q, state_d;

    logic [ADDR_W-1:0] base_q, addr_q, wbval_q;
    logic [NREG-1:0]   list_q, mask_q;
    addr_mode_e        mode_q;
    logic              load_q, wben_q;

    logic [ADDR_W-1:0] calc_first, calc_final;
    logic [CNT_W-1:0]  calc_count;
    logic [IDX_W-1:0]  pick_idx;
    logic              pick_hit, pick_more;

    lsm_span_calc #(.ADDR_W(ADDR_W), .NREG(NREG), .WORD_BYTES(WORD_BYTES)) u_span (
        .base       (base_q),
        .mask       (list_q),
        .mode       (mode_q),
        .first_addr (calc_first),
        .final_base (calc_final),
        .count      (calc_count)
    );

    lsm_low_pick #(.NREG(NREG)) u_pick (
        .mask (mask_q),
        .idx  (pick_idx),
        .hit  (pick_hit),
        .more (pick_more)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_SETUP;
            ST_SETUP:  state_d = (calc_count == '0) ? ST_FINISH : ST_XFER;
            ST_XFER:   if (ack_i && !pick_more) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // command and walk registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            list_q  <= '0;
            mode_q  <= AM_INC_AFTER;
            load_q  <= 1'b0;
            wben_q  <= 1'b0;
            addr_q  <= '0;
            mask_q  <= '0;
            wbval_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    base_q <= base_i;
                    list_q <= reg_mask_i;
                    mode_q <= addr_mode_e'(mode_i);
                    load_q <= load_i;
                    wben_q <= wb_en_i;
                end
                ST_SETUP: begin
                    addr_q  <= calc_first;
                    mask_q  <= list_q;
                    wbval_q <= calc_final;
                end
                ST_XFER: if (ack_i) begin
                    mask_q <= mask_q & ~(NREG'(1) << pick_idx);
                    addr_q <= addr_q + ADDR_W'(WORD_BYTES);
                end
                ST_FINISH: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy_o     = 1'b1;
        req_o      = 1'b0;
        done_o     = 1'b0;
        wb_valid_o = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy_o = 1'b0;
            ST_SETUP:  ;
            ST_XFER:   req_o = pick_hit;
            ST_FINISH: begin
                done_o     = 1'b1;
                wb_valid_o = wben_q;
            end
            default:   busy_o = 1'b0;
        endcase
    end

    assign req_addr_o = addr_q;
    assign req_reg_o  = pick_idx;
    assign req_load_o = load_q;
    assign wb_value_o = wbval_q;

    // R7: an unaccepted request keeps its contents
    a_r7_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        req_o && !ack_i |=> req_o && $stable(req_addr_o) && $stable(req_reg_o)
                            && $stable(req_load_o));

    // R2: next access one word higher
    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        req_o && ack_i |=> !req_o || (req_addr_o == $past(req_addr_o) + ADDR_W'(WORD_BYTES)));

    // R2: register indices rise
    a_r2_reg_rises: assert property (@(posedge clk) disable iff (!rst_n)
        req_o && ack_i |=> !req_o || (req_reg_o > $past(req_reg_o)));

    // R9: update offered only with completion
    a_r9_wb_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o |-> done_o);

    // R11: completion is a single-cycle pulse followed by idle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !busy_o);

    // R10: no request outside a running command
    a_r10_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> busy_o);
endmodule

// File: tb/lsm_addr_seq_bench.sv
module lsm_addr_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] base_i = '0;
    logic [15:0] reg_mask_i = '0;
    logic        load_i = 1'b0;
    logic [1:0]  mode_i = '0;
    logic        wb_en_i = 1'b0;
    logic        ack_i = 1'b0;
    logic        busy_o, req_o, req_load_o, done_o, wb_valid_o;
    logic [31:0] req_addr_o, wb_value_o;
    logic [3:0]  req_reg_o;

    lsm_addr_seq u_lsm_addr_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
        .reg_mask_i(reg_mask_i), .load_i(load_i), .mode_i(mode_i), .wb_en_i(wb_en_i),
        .busy_o(busy_o), .req_o(req_o), .req_addr_o(req_addr_o), .req_reg_o(req_reg_o),
        .req_load_o(req_load_o), .ack_i(ack_i), .done_o(done_o),
        .wb_valid_o(wb_valid_o), .wb_value_o(wb_value_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int t_wait = 1;
    int ack_cnt = 0;
    int obs_cnt = 0;

    // reference model state
    int          m_phase = 0;
    int          m_start = 0;
    int          m_n = 0;
    int          m_mode = 0;
    bit          m_ld = 0, m_wb = 0, m_fresh = 0;
    logic [31:0] m_wbval = '0;
    logic [31:0] q_addr[$];
    int          q_reg[$];

    function automatic string mtag(int m);
        case (m)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if (req_o && ack_i) obs_cnt = obs_cnt + 1;
            case (m_phase)
                0: if (start_i) begin
                    logic [31:0] lo;
                    int k;
                    m_n = $countones(reg_mask_i);
                    m_mode = int'(mode_i);
                    m_ld = load_i;
                    m_wb = wb_en_i;
                    m_start = cyc;
                    case (m_mode)
                        0: begin lo = base_i;                  m_wbval = base_i + 32'(4 * m_n); end
                        1: begin lo = base_i + 32'd4;          m_wbval = base_i + 32'(4 * m_n); end
                        2: begin lo = base_i - 32'(4 * m_n) + 32'd4; m_wbval = base_i - 32'(4 * m_n); end
                        default: begin lo = base_i - 32'(4 * m_n); m_wbval = base_i - 32'(4 * m_n); end
                    endcase
                    q_addr.delete();
                    q_reg.delete();
                    k = 0;
                    for (int r = 0; r < 16; r++) begin
                        if (reg_mask_i[r]) begin
                            q_addr.push_back(lo + 32'(4 * k));
                            q_reg.push_back(r);
                            k++;
                        end
                    end
                    m_phase = 1;
                end
                1: begin m_phase = (m_n == 0) ? 3 : 2; m_fresh = 1; end
                2: if (ack_i) begin
                    void'(q_addr.pop_front());
                    void'(q_reg.pop_front());
                    m_fresh = 1;
                    if (q_addr.size() == 0) m_phase = 3;
                end else m_fresh = 0;
                default: m_phase = 0;
            endcase
        end
    end

    // memory side: acknowledge after t_wait cycles of request
    always @(negedge clk) begin
        if (req_o) begin
            ack_cnt = ack_cnt + 1;
            if (ack_cnt >= t_wait) begin ack_i = 1'b1; ack_cnt = 0; end
            else ack_i = 1'b0;
        end else begin
            ack_i = 1'b0;
            ack_cnt = 0;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk(req_o == (m_phase == 2), "R2", "req_o", req_o, m_phase == 2);
            if (req_o && m_phase == 2) begin
                string tg;
                tg = m_fresh ? mtag(m_mode) : "R7";
                chk(req_addr_o == q_addr[0], tg, "req_addr_o", req_addr_o, q_addr[0]);
                chk(int'(req_reg_o) == q_reg[0], "R2", "req_reg_o", req_reg_o, q_reg[0]);
                chk(req_load_o == m_ld, "R7", "req_load_o", req_load_o, m_ld);
            end
            chk(done_o == (m_phase == 3), "R11", "done_o", done_o, m_phase == 3);
            chk(wb_valid_o == (m_phase == 3 && m_wb), "R9", "wb_valid_o",
                wb_valid_o, m_phase == 3 && m_wb);
            if (done_o && m_phase == 3) begin
                chk(cyc - m_start + 1 == 2 + m_n * t_wait, "R11", "latency",
                    cyc - m_start + 1, 2 + m_n * t_wait);
                if (m_wb)
                    chk(wb_value_o == m_wbval, (m_n == 0) ? "R8" : mtag(m_mode),
                        "wb_value_o", wb_value_o, m_wbval);
            end
            chk(busy_o == (m_phase != 0), "R10", "busy_o", busy_o, m_phase != 0);
        end
    end

    task automatic run_op(logic [31:0] b, logic [15:0] m, int md, bit ld, bit wb,
                          int t, bit inject);
        int n0;
        t_wait = t;
        obs_cnt = 0;
        n0 = $countones(m);
        @(negedge clk);
        base_i = b; reg_mask_i = m; mode_i = 2'(md); load_i = ld; wb_en_i = wb;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (inject) begin
            @(negedge clk);
            @(negedge clk);
            base_i = 32'hDEAD_0000; reg_mask_i = 16'h0001; mode_i = 2'd3;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (m_phase != 0) @(negedge clk);
        if (inject) begin
            chk(obs_cnt == n0, "R10", "access count with injected start", obs_cnt, n0);
            repeat (3) @(negedge clk);
            chk(busy_o == 1'b0, "R10", "no second command", busy_o, 0);
        end else begin
            chk(obs_cnt == n0, "R2", "access count", obs_cnt, n0);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy_o == 0 && req_o == 0, "R1", "busy/req in reset", {busy_o, req_o}, 0);
        chk(done_o == 0 && wb_valid_o == 0, "R1", "done/wb in reset", {done_o, wb_valid_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy_o == 0 && req_o == 0 && done_o == 0, "R1", "idle after reset",
            {busy_o, req_o, done_o}, 0);

        run_op(32'h0000_1000, 16'h0012, 0, 1, 1, 1, 0);   // R3
        run_op(32'h0000_2000, 16'h8001, 1, 0, 1, 2, 0);   // R4
        run_op(32'h0000_3000, 16'hFFFF, 2, 1, 1, 1, 0);   // R5
        run_op(32'h0000_4000, 16'h00F0, 3, 0, 1, 3, 0);   // R6
        run_op(32'h0000_0004, 16'h0003, 3, 1, 1, 1, 0);   // R6 wrap below zero
        run_op(32'hFFFF_FFF8, 16'h0007, 1, 0, 1, 2, 0);   // R4 wrap above top
        run_op(32'h0000_0040, 16'h0000, 3, 1, 1, 1, 0);   // R8 empty
        run_op(32'h0000_0080, 16'h0000, 0, 0, 1, 2, 0);   // R8 empty
        run_op(32'h0000_5000, 16'h0A50, 2, 1, 0, 2, 0);   // R9 no update
        run_op(32'h0000_6000, 16'h000F, 0, 1, 1, 1, 1);   // R10 injected start
        run_op(32'h0000_7000, 16'h4002, 3, 0, 0, 1, 1);   // R10 + R9

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule